// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sits beside a small 8-bit processor core and decides, cycle by cycle, whether the core and its peripherals receive clock pulses. Software writes a power control register over a simple write port. Setting the idle bit stops the processor clock while the peripheral clock keeps running. Setting the power-down bit stops both clocks. Software can also set both bits in the same write, and power-down then takes precedence. Two general-purpose flag bits in the same register belong to software alone, so an interrupt handler can tell whether it woke the core from idle.

The clocks leave the block as enable signals, not as gated clocks. The enables are registered on the falling edge of the source clock, so a clock gate downstream sees them settle while the clock is low and never produces a runt pulse. An enabled, pending interrupt wakes the block from either low-power mode, and the hardware clears the mode bit. A high level on the reset input releases the clocks at once, without waiting for a clock edge. A separate select input halves the clock rate of the core and of the peripherals. The block adopts a new select value only at a divider phase boundary.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Register layout: bit 0 is idle, bit 1 is power-down, bit 2 is flag 0 and bit 3 is flag 1. A write in run mode with bit 0 set and bit 1 clear moves `pwr_mode` to idle (code 1) at the next rising edge.
- R2: In idle, `cpu_clk_en` is low and `per_clk_en` keeps its run-mode value. Both enables are registered on the falling edge that follows the rising edge that changed the mode.
- R3: A write with bits 0 and 1 both set enters power-down (code 2) only. The register reads back with bit 1 set and bit 0 clear, and an interrupt then returns the block to run mode (code 0), not to idle.
- R4: While the block is in idle or power-down, a high `irq_pending` at a rising edge clears both mode bits and returns `pwr_mode` to run. Both enables come back at the following falling edge.
- R5: While `rst` is high, `cpu_clk_en` and `per_clk_en` are high and `pwr_mode` reads run, with no clock edge needed. The register clears to zero at the first rising edge during reset.
- R6: In power-down, `cpu_clk_en` and `per_clk_en` are both low.
- R7: The two flag bits take the values written in run mode and keep them across mode entry and interrupt wake-up. Hardware never changes them.
- R8: Bits 7 to 4 of the write data are ignored and read as zero. Writes made while the block is in idle or power-down are ignored.
- R9: `irq_pending` in run mode has no effect on the register or on the mode.
- R10: When `div_active` is high, each enable is high on at most one of any two consecutive cycles, so run mode gives 4 enabled cycles in 8. `half_speed` is adopted into `div_active` only at a rising edge that ends a two-cycle divider phase. That is the second, fourth and so on rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Active-high reset; releases the clocks without waiting for an edge |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_data | input | 8 | Register write data |
| bus_rd_data | output | 8 | Current register contents |
| irq_pending | input | 1 | An enabled interrupt is pending |
| half_speed | input | 1 | Requests clock division by two |
| cpu_clk_en | output | 1 | Processor clock enable, registered on the falling edge |
| per_clk_en | output | 1 | Peripheral clock enable, registered on the falling edge |
| div_active | output | 1 | Division by two is in effect |
| pwr_mode | output | 2 | 0 run, 1 idle, 2 power-down |

## Verification
A stimulus table walks the register through single idle writes, a combined idle and power-down write, flag-only writes, writes with upper bits set, writes made during a low-power mode, and interrupts that arrive in run mode and in each low-power mode. Each of these patterns separates the priority, wake and flag-preservation paths from one another. Directed cases then raise reset in the middle of idle and sample the enables before any edge, which separates an asynchronous release from a synchronous one. Further cases request half speed on an odd edge and on an even edge after reset and count the enabled cycles, which separates boundary-aligned adoption from immediate adoption.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_PDOWN = 2'd2
    } pm_mode_e;

    // Power control register, bit 0 first from the right
    typedef struct packed {
        logic flag1;
        logic flag0;
        logic pdown;
        logic idle;
    } pcr_t;

    localparam int PCR_W = $bits(pcr_t);

    function automatic pm_mode_e decode_mode(input pcr_t r);
        if (r.pdown)
            return PM_PDOWN;
        else if (r.idle)
            return PM_IDLE;
        else
            return PM_RUN;
    endfunction

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wake_req,
    output pcr_t              pcr_q,
    output pm_mode_e          mode
);

    pcr_t wr_val;

    // Power-down wins over idle when both arrive in one write
    always_comb begin
        wr_val       = pcr_t'(wr_data[PCR_W-1:0]);
        wr_val.idle  = wr_val.idle & ~wr_val.pdown;
    end

    assign mode = decode_mode(pcr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcr_q <= '0;
        end else if (mode != PM_RUN) begin
            if (wake_req) begin
                pcr_q.idle  <= 1'b0;
                pcr_q.pdown <= 1'b0;
            end
        end else if (wr_en) begin
            pcr_q <= wr_val;
        end
    end

endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div #(
    parameter int RATIO = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic half_req,
    output logic sel_q,
    output logic tick
);

    localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);

    logic [PH_W-1:0] phase_q;
    logic            at_last;

    assign at_last = (phase_q == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            sel_q   <= 1'b0;
        end else begin
            phase_q <= at_last ? '0 : phase_q + 1'b1;
            if (at_last)
                sel_q <= half_req;
        end
    end

    // One enabled cycle per phase when division is in effect
    assign tick = ~sel_q | at_last;

endmodule

// File: rtl/pmc_gate.sv
module pmc_gate (
    input  logic clk,
    input  logic rst,
    input  logic cpu_want,
    input  logic per_want,
    input  logic tick,
    output logic cpu_en_q,
    output logic per_en_q
);

    // Enables settle while the clock is low
    always_ff @(negedge clk) begin
        if (rst) begin
            cpu_en_q <= 1'b0;
            per_en_q <= 1'b0;
        end else begin
            cpu_en_q <= cpu_want & tick;
            per_en_q <= per_want & tick;
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wr_data,
    output logic [DATA_W-1:0] bus_rd_data,
    input  logic              irq_pending,
    input  logic              half_speed,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              div_active,
    output logic [1:0]        pwr_mode
);

    pcr_t     pcr_q;
    pm_mode_e mode_int;
    logic     tick;
    logic     cpu_en_q;
    logic     per_en_q;

    pmc_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr_en),
        .wr_data  (bus_wr_data),
        .wake_req (irq_pending),
        .pcr_q    (pcr_q),
        .mode     (mode_int)
    );

    pmc_clk_div #(.RATIO(2)) u_div (
        .clk      (clk),
        .rst      (rst),
        .half_req (half_speed),
        .sel_q    (div_active),
        .tick     (tick)
    );

    pmc_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .cpu_want (mode_int == PM_RUN),
        .per_want (mode_int != PM_PDOWN),
        .tick     (tick),
        .cpu_en_q (cpu_en_q),
        .per_en_q (per_en_q)
    );

    // Reset level releases the clocks without any edge
    assign cpu_clk_en  = rst | cpu_en_q;
    assign per_clk_en  = rst | per_en_q;
    assign pwr_mode    = rst ? PM_RUN : mode_int;
    assign bus_rd_data = {{(DATA_W-PCR_W){1'b0}}, pcr_q};

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr_en,
    input logic [7:0] bus_wr_data,
    input logic [7:0] bus_rd_data,
    input logic       irq_pending,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       div_active,
    input logic [1:0] pwr_mode
);

    a_r1_idle_entry: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_wr_data[1:0] == 2'b01 && pwr_mode == 2'd0) |=> (pwr_mode == 2'd1));

    a_r2_idle_cpu_stopped: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd1) |-> (!cpu_clk_en));

    a_r3_pdown_priority: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_wr_data[1:0] == 2'b11 && pwr_mode == 2'd0) |=> (pwr_mode == 2'd2));

    a_r4_wake_on_irq: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode != 2'd0 && irq_pending) |=> (pwr_mode == 2'd0));

    a_r6_pdown_all_stopped: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'd2) |-> (!cpu_clk_en && !per_clk_en));

    a_r7_flags_kept: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr_en) |=> (bus_rd_data[3:2] == $past(bus_rd_data[3:2])));

    a_r10_half_rate: assert property (@(posedge clk) disable iff (rst)
        (div_active && $past(div_active)) |-> !(per_clk_en && $past(per_clk_en)));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_data (bus_rd_data),
    .irq_pending (irq_pending),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .div_active  (div_active),
    .pwr_mode    (pwr_mode)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_wr_data = 8'h00;
    logic [7:0] bus_rd_data;
    logic       irq_pending = 1'b0;
    logic       half_speed = 1'b0;
    logic       cpu_clk_en;
    logic       per_clk_en;
    logic       div_active;
    logic [1:0] pwr_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .irq_pending (irq_pending),
        .half_speed  (half_speed),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .div_active  (div_active),
        .pwr_mode    (pwr_mode)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       wr;
        logic [7:0] wd;
        logic       irq;
        logic [1:0] mode;
        logic       cpu;
        logic       per;
        logic [7:0] rd;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd7,  1'b1, 8'h0C, 1'b0, 2'd0, 1'b1, 1'b1, 8'h0C}, // R7 flags written
        '{4'd1,  1'b1, 8'h0D, 1'b0, 2'd1, 1'b0, 1'b1, 8'h0D}, // R1 idle entry
        '{4'd2,  1'b0, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 8'h0D}, // R2 idle holds
        '{4'd8,  1'b1, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 8'h0D}, // R8 write in idle ignored
        '{4'd4,  1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 1'b1, 8'h0C}, // R4 wake, flags kept
        '{4'd3,  1'b1, 8'h03, 1'b0, 2'd2, 1'b0, 1'b0, 8'h02}, // R3 both bits
        '{4'd6,  1'b0, 8'h00, 1'b0, 2'd2, 1'b0, 1'b0, 8'h02}, // R6 pdown holds
        '{4'd3,  1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 1'b1, 8'h00}, // R3 wake to run
        '{4'd6,  1'b1, 8'h02, 1'b0, 2'd2, 1'b0, 1'b0, 8'h02}, // R6 pdown only
        '{4'd4,  1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 1'b1, 8'h00}, // R4 wake from pdown
        '{4'd8,  1'b1, 8'hF5, 1'b0, 2'd1, 1'b0, 1'b1, 8'h05}, // R8 upper bits ignored
        '{4'd7,  1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 1'b1, 8'h04}, // R7 flag survives wake
        '{4'd9,  1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 1'b1, 8'h04}, // R9 irq in run
        '{4'd1,  1'b1, 8'h01, 1'b1, 2'd1, 1'b0, 1'b1, 8'h01}, // R1 write wins in run
        '{4'd2,  1'b0, 8'h00, 1'b0, 2'd1, 1'b0, 1'b1, 8'h01}, // R2 still idle
        '{4'd4,  1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 1'b1, 8'h00}  // R4 wake again
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Rising edge, then past the following falling edge
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    initial begin
        int cnt;
        // Reset state, R5
        step(); step(); step();
        check("R5", "rd in reset", bus_rd_data, 8'h00);
        check("R5", "mode in reset", pwr_mode, 0);
        check("R5", "cpu en in reset", cpu_clk_en, 1);
        rst = 1'b0;
        step();
        check("R5", "cpu en after reset", cpu_clk_en, 1);
        check("R5", "per en after reset", per_clk_en, 1);
        check("R10", "div after reset", div_active, 0);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d", VECS[i].req);
            bus_wr_en   = VECS[i].wr;
            bus_wr_data = VECS[i].wd;
            irq_pending = VECS[i].irq;
            step();
            bus_wr_en   = 1'b0;
            irq_pending = 1'b0;
            check(tg, $sformatf("vec %0d mode", i), pwr_mode, VECS[i].mode);
            check(tg, $sformatf("vec %0d cpu en", i), cpu_clk_en, VECS[i].cpu);
            check(tg, $sformatf("vec %0d per en", i), per_clk_en, VECS[i].per);
            check(tg, $sformatf("vec %0d rd", i), bus_rd_data, VECS[i].rd);
        end

        // R5: reset raised in idle releases clocks before any edge
        bus_wr_en = 1'b1; bus_wr_data = 8'h09;
        step();
        bus_wr_en = 1'b0;
        check("R1", "idle before reset", pwr_mode, 1);
        rst = 1'b1;
        #1;
        check("R5", "async cpu en", cpu_clk_en, 1);
        check("R5", "async mode", pwr_mode, 0);
        step();
        check("R5", "register cleared", bus_rd_data, 8'h00);
        step();

        // R10: request on odd edge is held until the phase ends
        rst = 1'b0; half_speed = 1'b1;
        step();
        check("R10", "not adopted on first edge", div_active, 0);
        step();
        check("R10", "adopted on second edge", div_active, 1);
        step(); step();
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            step();
            cnt += int'(cpu_clk_en);
        end
        check("R10", "cpu enables in 8 halved cycles", cnt, 4);
        half_speed = 1'b0;
        step(); step(); step(); step();
        check("R10", "division released", div_active, 0);
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            step();
            cnt += int'(per_clk_en);
        end
        check("R10", "per enables in 8 full cycles", cnt, 8);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule